// File: doc/BRIEF.md
# PWM-Synchronized Pulse Generator

This block emits a single positive pulse that is locked to the timebase of a center-aligned PWM generator. The PWM side provides three inputs: a one-clock strobe at each period center, the current period length `period` in timer clocks, and a one-clock reload strobe marking the instant when new modulation values are taken. The pulse repeats once per programmable number of PWM periods. Its rising edge sits a signed number of timer clocks away from a period center, either after it or ahead of it, and its high time is programmable.

A rising edge placed after a center is timed from that center. A rising edge placed ahead of a center is timed from the center before it, using the period value presented with that earlier strobe, so the edge follows period changes made at run time. Offsets larger than the quarter-period rule allows are clamped. The prescaler comes from one of two sources. In direct mode the host drives it continuously. In synchronized mode a staged value is captured only at the PWM reload strobe, so the pulse rate changes at the same instant as the PWM's own reload rate. An interrupt strobe marks each rising edge.

Top module: `pwm_sync_pulse`

## Requirements
- R1: While `rst_n` is low, `pulse_out` and `irq` are 0, the captured prescaler is 1 and the period count is set so that the first center strobe after reset is an anchor.
- R2: With a non-negative `offset` (bit 15 clear), an anchor strobe sampled at clock edge s makes `pulse_out` rise at edge s + `offset`. An offset of 0 rises at edge s.
- R3: With a negative `offset` (bit 15 set, two's complement), the strobe that immediately precedes an anchor, sampled at edge s with `period` = T, makes `pulse_out` rise at edge s + T − |offset|. T is the period value presented with that strobe.
- R4: The magnitude of `offset` is clamped to L = (`period` >> 2) − 1, or to 0 when `period` >> 2 is 0. The value −32768 is clamped like any other negative value.
- R5: Anchors are the 1st, (N+1)th, (2N+1)th, ... center strobes after reset, where N is the effective prescaler. A prescaler of 0 acts as 1. The value is taken each time the count restarts at an anchor.
- R6: With `sync_en` = 1, the effective prescaler is a register that loads `presc_next` only on a `reload_stb` cycle, and `presc_direct` has no effect. With `sync_en` = 0, `presc_direct` is used.
- R7: `pulse_out` stays high for exactly `width` clocks. A `width` of 0 gives a one-clock pulse.
- R8: `irq` is high for exactly one clock, and it is set at the same edge at which `pulse_out` goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| center_stb | input | 1 | One-clock strobe at each PWM period center |
| period | input | 16 | Current PWM period in timer clocks, valid with `center_stb` |
| reload_stb | input | 1 | One-clock strobe at the PWM reload instant |
| offset | input | 16 | Signed rising-edge offset from the period center, in clocks |
| width | input | 16 | Pulse high time in clocks |
| presc_next | input | 16 | Staged prescaler, captured at reload in synchronized mode |
| presc_direct | input | 16 | Prescaler used in direct mode |
| sync_en | input | 1 | 1 selects synchronized prescaler mode |
| pulse_out | output | 1 | Synchronized pulse |
| irq | output | 1 | One-clock strobe at each rising edge |

## Verification
The hardest case to reach is a negative offset combined with a prescaler above 1. In that case the edge has to be launched from the strobe just before the anchor, not from the anchor itself. The stimulus runs seven centers with a prescaler of 3 and checks that exactly two pulses appear, each ahead of the 4th and 7th strobes. The synchronized mode is driven into the state where a staged prescaler value waits for a reload, and the bench confirms that the pulse rate changes only after the reload strobe and not when the staged value is written. Period tracking is covered by one center that presents a longer period, after which the next early edge must move with it.

// File: rtl/pwm_sync_pulse.sv
module pwm_sync_pulse #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         center_stb,
  input  logic [W-1:0] period,
  input  logic         reload_stb,
  input  logic [W-1:0] offset,
  input  logic [W-1:0] width,
  input  logic [W-1:0] presc_next,
  input  logic [W-1:0] presc_direct,
  input  logic         sync_en,
  output logic         pulse_out,
  output logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] presc_q, per_cnt, rdly, fdly;
  logic         armed;

  logic [W-1:0] presc_sel, presc_use, quarter, lim, mag_s, rise_dly, width_eff;
  logic [W:0]   ext, mag;
  logic         neg, anchor, pre_anchor, fire, rise_now;

  assign presc_sel  = sync_en ? presc_q : presc_direct;
  assign presc_use  = (presc_sel == '0) ? ONE : presc_sel;
  assign anchor     = center_stb && (per_cnt <= ONE);
  assign pre_anchor = center_stb && ((per_cnt == TWO) || ((per_cnt <= ONE) && (presc_use == ONE)));

  assign neg      = offset[W-1];
  assign ext      = {offset[W-1], offset};
  assign mag      = neg ? (~ext + 1'b1) : ext;
  assign quarter  = period >> 2;
  assign lim      = (quarter == '0) ? '0 : quarter - ONE;
  assign mag_s    = (mag > {1'b0, lim}) ? lim : mag[W-1:0];
  assign rise_dly = neg ? (period - mag_s) : mag_s;

  assign width_eff = (width == '0) ? ONE : width;
  assign fire      = !armed && (neg ? pre_anchor : anchor);
  assign rise_now  = (fire && (rise_dly == '0)) || (armed && (rdly == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q   <= ONE;
      per_cnt   <= ONE;
      armed     <= 1'b0;
      rdly      <= '0;
      fdly      <= '0;
      pulse_out <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (reload_stb) presc_q <= presc_next;
      if (center_stb) per_cnt <= (per_cnt <= ONE) ? presc_use : per_cnt - ONE;

      if (fire && (rise_dly != '0)) begin
        armed <= 1'b1;
        rdly  <= rise_dly - ONE;
      end else if (armed) begin
        if (rdly == '0) armed <= 1'b0;
        else            rdly  <= rdly - ONE;
      end

      if (rise_now) begin
        pulse_out <= 1'b1;
        irq       <= !pulse_out;
        fdly      <= width_eff - ONE;
      end else if (pulse_out) begin
        if (fdly == '0) pulse_out <= 1'b0;
        else            fdly      <= fdly - ONE;
      end
    end
  end

  a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pulse_out && !$past(pulse_out)));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_rise_flags_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> irq);

  a_r6_presc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_stb |=> $stable(presc_q));

  a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    per_cnt != '0);
endmodule

// File: tb/pwm_sync_pulse_bench.sv
module pwm_sync_pulse_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        center_stb = 1'b0;
  logic [15:0] period = 16'd40;
  logic        reload_stb = 1'b0;
  logic [15:0] offset = '0;
  logic [15:0] width = 16'd1;
  logic [15:0] presc_next = 16'd1;
  logic [15:0] presc_direct = 16'd1;
  logic        sync_en = 1'b0;
  logic        pulse_out, irq;

  pwm_sync_pulse u_pwm_sync_pulse (
    .clk(clk), .rst_n(rst_n), .center_stb(center_stb), .period(period),
    .reload_stb(reload_stb), .offset(offset), .width(width),
    .presc_next(presc_next), .presc_direct(presc_direct), .sync_en(sync_en),
    .pulse_out(pulse_out), .irq(irq)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int nchk = 0, nfail = 0;
  int rise_c [0:31];
  int stb_c  [0:31];
  int nrise = 0, ns = 0, nirq = 0, bad_irq = 0, last_fall = 0;
  logic prev_p = 1'b0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_out && !prev_p) begin
        if (nrise < 32) rise_c[nrise] = cyc;
        nrise++;
      end
      if (!pulse_out && prev_p) last_fall = cyc;
      if (irq) begin
        nirq++;
        if (!(pulse_out && !prev_p)) bad_irq++;
      end
    end
    prev_p = pulse_out;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int mv, input int pw, input int pd, input int pn, input bit se);
    @(negedge clk);
    rst_n = 1'b0;
    offset = mv[15:0]; width = pw[15:0]; presc_direct = pd[15:0];
    presc_next = pn[15:0]; sync_en = se; center_stb = 1'b0; reload_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nrise = 0; ns = 0; nirq = 0; bad_irq = 0; last_fall = 0;
  endtask

  task automatic center(input int t);
    @(negedge clk);
    period = t[15:0];
    center_stb = 1'b1;
    if (ns < 32) stb_c[ns] = cyc + 1;
    ns++;
    @(negedge clk);
    center_stb = 1'b0;
    repeat (t - 2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pulse_out in reset", int'(pulse_out), 0);
    chk("R1 irq in reset", int'(irq), 0);
  endtask

  task automatic t_positive;
    start(5, 3, 1, 1, 0);
    center(40); center(40);
    idle(60);
    chk("R1 first strobe is anchor", rise_c[0], stb_c[0] + 5);
    chk("R2 rise after center", rise_c[1], stb_c[1] + 5);
    chk("R7 width 3", last_fall - rise_c[1], 3);
    chk("R8 irq count", nirq, 2);
    chk("R8 irq aligned with rise", bad_irq, 0);
  endtask

  task automatic t_negative;
    start(-6, 3, 1, 1, 0);
    center(40); center(40);
    idle(80);
    chk("R3 early edge", rise_c[0], stb_c[0] + 34);
    chk("R3 early edge second", rise_c[1], stb_c[1] + 34);
    chk("R3 pulse count", nrise, 2);
  endtask

  task automatic t_track;
    start(-6, 2, 1, 1, 0);
    center(40); center(60);
    idle(80);
    chk("R3 tracks longer period", rise_c[1], stb_c[1] + 54);
  endtask

  task automatic t_saturate;
    start(20, 2, 1, 1, 0);
    center(40);
    idle(60);
    chk("R4 positive clamp", rise_c[0], stb_c[0] + 9);
    start(-20, 2, 1, 1, 0);
    center(40);
    idle(60);
    chk("R4 negative clamp", rise_c[0], stb_c[0] + 31);
    start(-32768, 2, 1, 1, 0);
    center(40);
    idle(60);
    chk("R4 most negative clamp", rise_c[0], stb_c[0] + 31);
    start(5, 1, 1, 1, 0);
    center(3);
    idle(10);
    chk("R4 tiny period clamps to zero", rise_c[0], stb_c[0]);
  endtask

  task automatic t_width0;
    start(2, 0, 1, 1, 0);
    center(40);
    idle(50);
    chk("R7 zero width gives one clock", last_fall - rise_c[0], 1);
  endtask

  task automatic t_presc;
    start(4, 2, 3, 1, 0);
    for (int i = 0; i < 7; i++) center(40);
    idle(60);
    chk("R5 pulses per 7 centers at N=3", nrise, 3);
    chk("R5 second anchor", rise_c[1], stb_c[3] + 4);
    chk("R5 third anchor", rise_c[2], stb_c[6] + 4);
    start(4, 2, 0, 1, 0);
    for (int i = 0; i < 3; i++) center(40);
    idle(60);
    chk("R5 zero prescaler acts as one", nrise, 3);
  endtask

  task automatic t_presc_neg;
    start(-6, 2, 3, 1, 0);
    for (int i = 0; i < 7; i++) center(40);
    idle(60);
    chk("R3 R5 early pulses count", nrise, 2);
    chk("R3 R5 early before 4th center", rise_c[0], stb_c[2] + 34);
    chk("R3 R5 early before 7th center", rise_c[1], stb_c[5] + 34);
  endtask

  task automatic t_sync;
    start(4, 2, 1, 3, 1);
    for (int i = 0; i < 3; i++) center(40);
    idle(10);
    chk("R6 staged prescaler ignored before reload", nrise, 3);
    @(negedge clk); reload_stb = 1'b1;
    @(negedge clk); reload_stb = 1'b0;
    for (int i = 0; i < 4; i++) center(40);
    idle(60);
    chk("R6 rate after reload", nrise, 5);
    chk("R6 anchor after reload", rise_c[3], stb_c[3] + 4);
    chk("R6 next anchor three later", rise_c[4], stb_c[6] + 4);
  endtask

  initial begin
    t_reset();
    t_positive();
    t_negative();
    t_track();
    t_saturate();
    t_width0();
    t_presc();
    t_presc_neg();
    t_sync();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog: act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule